// File: doc/BRIEF.md
# Bitmap cursor and crosshair overlay

This block produces the overlay for a hardware cursor on a raster display that emits one pixel per clock. For every pixel it takes the screen X/Y counters and a video-active flag. It reads the matching word of an external 64x64 two-plane cursor bitmap and returns two bits: `curActive` says the overlay owns the pixel, and `curData` selects the overlay colour. The bitmap holds 512 words of 16 bits. Each word covers 8 horizontal pixels, with the mask plane in the upper byte and the colour plane in the lower byte. Eight consecutive words make up one bitmap row.

The cursor position registers use the coordinate space of the display timing, not screen space. The block converts them to a screen origin. Horizontally it adds a constant that depends on the pixel multiplexing mode and subtracts the skew from sync fall to active video. Vertically it adds 32 and subtracts the vertical skew. A crosshair can be drawn as well. Its two lines pass through the centre of the cursor box, have a selectable odd thickness and may be clipped to a window. The crosshair is merged with the bitmap cursor by an OR or an XOR rule taken from the command byte.

The bitmap address is issued combinationally in the same cycle as the pixel. The bitmap store answers one clock later. The overlay bits for a pixel appear two clocks after that pixel is presented.

Top module: `cursorOverlay`

## Requirements
- R1: While reset is asserted, and on the first output after reset is released, `curActive` and `curData` are 0.
- R2: In the cycle a pixel is presented inside the cursor box, `bmAddr` equals row*8 + column/8, where row and column are the pixel's offsets from the box origin (0..63). The overlay bits for that pixel appear on the outputs exactly two clocks later.
- R3: Within a bitmap word, mask bit 15-c and colour bit 7-c belong to pixel column c (0..7) of the word's 8-pixel group. Bit 7 of each byte is the leftmost pixel. A cursor pixel is active only where its mask bit is 1, and its colour is the colour-plane bit.
- R4: Command bit 6 enables the bitmap cursor. With bit 6 clear, whatever the mode bits hold, no bitmap pixel is active.
- R5: Command bits 3:2 select the multiplex mode (0: 1:1, 1: 4:1, 2: 5:1, 3: treated as 1:1). The box's left screen column is curX + K - 412, modulo 4096, with K = 37, 52 or 57 for modes 1:1, 4:1 and 5:1.
- R6: The box's top screen row is curY + 32 - 68, modulo 4096. The box covers 64 columns and 64 rows from its origin.
- R7: Command bit 5 enables the crosshair. Its vertical and horizontal lines are centred on box column 32 and box row 32 and are 2t+1 pixels thick, with t taken from command bits 1:0 (thickness 1, 3, 5 or 7).
- R8: With command bit 4 set, active = cursor OR crosshair and colour = (cursor colour) OR crosshair. With bit 4 clear, active is the same but colour = (cursor colour) XOR crosshair.
- R9: When winX, winY, winW and winH are all 0, the crosshair is unbounded. Otherwise it is drawn only at screen pixels with winX <= X < winX+winW and winY <= Y < winY+winH.
- R10: A pixel presented with `vidActive` low yields `curActive` = 0 and `curData` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pixX | input | 12 | Screen column of the current pixel |
| pixY | input | 12 | Screen row of the current pixel |
| vidActive | input | 1 | Pixel lies in active video |
| cmd | input | 8 | Command byte: enables, merge rule, mode, thickness |
| curX | input | 12 | Horizontal cursor register value |
| curY | input | 12 | Vertical cursor register value |
| winX | input | 12 | Crosshair window left column |
| winY | input | 12 | Crosshair window top row |
| winW | input | 12 | Crosshair window width |
| winH | input | 12 | Crosshair window height |
| bmData | input | 16 | Bitmap word, one clock after `bmAddr` |
| bmAddr | output | 9 | Bitmap word address |
| curActive | output | 1 | Overlay owns this pixel |
| curData | output | 1 | Overlay colour bit |

## Verification
A wrong origin offset or mode constant moves the whole cursor image by a fixed number of pixels. The first swept row that crosses the box then shows a run of mismatches. A wrong bit order inside a word mirrors each 8-pixel group, and a wrong address packing scrambles rows; both show within the first row of the bitmap. A merge-rule or thickness fault appears on the first pixel where the two lines overlap the cursor or where the line edge falls. A pipeline misalignment shifts every pixel by one column and fails at the first edge of the box. Every such fault reaches the ports two clocks after the offending pixel.

// File: rtl/cursorPkg.sv
package cursorPkg;
  // Decoded command fields handed from control to datapath.
  typedef struct packed {
    logic       curEn;      // bitmap cursor enabled
    logic       xhEn;       // crosshair enabled
    logic       orMode;     // 1: OR merge, 0: XOR merge
    logic [1:0] halfThick;  // crosshair half-width t, thickness 2t+1
    logic [1:0] muxSel;     // 0: 1:1, 1: 4:1, 2: 5:1
    logic       winOn;      // a crosshair window is programmed
  } ctlT;
endpackage

// File: rtl/cursorCtrl.sv
module cursorCtrl
  import cursorPkg::*;
#(
  parameter int CW      = 12,
  parameter int BIT_CUR = 6,
  parameter int BIT_XH  = 5,
  parameter int BIT_OR  = 4,
  parameter int BIT_MUX = 2
) (
  input  logic [7:0]    cmd,
  input  logic [CW-1:0] winX,
  input  logic [CW-1:0] winY,
  input  logic [CW-1:0] winW,
  input  logic [CW-1:0] winH,
  output ctlT           ctl
);
  logic [1:0] modeRaw;

  always_comb begin
    modeRaw       = cmd[BIT_MUX +: 2];
    ctl.curEn     = cmd[BIT_CUR];
    ctl.xhEn      = cmd[BIT_XH];
    ctl.orMode    = cmd[BIT_OR];
    ctl.halfThick = cmd[1:0];
    // the unused mode code falls back to direct multiplexing
    ctl.muxSel    = (modeRaw == 2'd3) ? 2'd0 : modeRaw;
    ctl.winOn     = (|winX) | (|winY) | (|winW) | (|winH);
  end
endmodule

// File: rtl/cursorPath.sv
module cursorPath
  import cursorPkg::*;
#(
  parameter int CW       = 12,
  parameter int DIM_LOG  = 6,
  parameter int WORD_LOG = 3,
  parameter int HSKEW    = 412,
  parameter int VSKEW    = 68,
  parameter int VBASE    = 32,
  parameter int MUX0K    = 37,
  parameter int MUX1K    = 52,
  parameter int MUX2K    = 57,
  localparam int DIM     = 1 << DIM_LOG,
  localparam int HALF    = DIM / 2,
  localparam int WPIX    = 1 << WORD_LOG,
  localparam int DW      = 2 * WPIX,
  localparam int AW      = 2 * DIM_LOG - WORD_LOG
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] pixX,
  input  logic [CW-1:0] pixY,
  input  logic          vidActive,
  input  logic [CW-1:0] curX,
  input  logic [CW-1:0] curY,
  input  logic [CW-1:0] winX,
  input  logic [CW-1:0] winY,
  input  logic [CW-1:0] winW,
  input  logic [CW-1:0] winH,
  input  ctlT           ctl,
  input  logic [DW-1:0] bmData,
  output logic [AW-1:0] bmAddr,
  output logic          curActive,
  output logic          curData
);
  logic [CW-1:0] muxK, originX, originY, dx, dy;
  logic [CW-1:0] ctrX, ctrY, dvx, dvy, span, relWx, relWy;
  logic          inBox, vHit, hHit, inWin, xhHit;

  // stage 1 registers
  logic                s1Box, s1Xh, s1Vid, s1CurEn, s1Or;
  logic [WORD_LOG-1:0] s1Col;

  // stage 2 merge terms
  logic mBit, dBit, cp, cd;

  always_comb begin
    unique case (ctl.muxSel)
      2'd1:    muxK = CW'(MUX1K);
      2'd2:    muxK = CW'(MUX2K);
      default: muxK = CW'(MUX0K);
    endcase
    originX = curX + muxK - CW'(HSKEW);
    originY = curY + CW'(VBASE) - CW'(VSKEW);
    dx      = pixX - originX;
    dy      = pixY - originY;
    inBox   = (dx[CW-1:DIM_LOG] == '0) && (dy[CW-1:DIM_LOG] == '0);
    bmAddr  = {dy[DIM_LOG-1:0], dx[DIM_LOG-1:WORD_LOG]};

    ctrX    = originX + CW'(HALF);
    ctrY    = originY + CW'(HALF);
    span    = CW'({ctl.halfThick, 1'b1});
    dvx     = pixX - ctrX + CW'(ctl.halfThick);
    dvy     = pixY - ctrY + CW'(ctl.halfThick);
    vHit    = dvx < span;
    hHit    = dvy < span;

    relWx   = pixX - winX;
    relWy   = pixY - winY;
    inWin   = !ctl.winOn || ((relWx < winW) && (relWy < winH));
    xhHit   = ctl.xhEn && inWin && (vHit || hHit);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1Box   <= 1'b0;
      s1Xh    <= 1'b0;
      s1Vid   <= 1'b0;
      s1CurEn <= 1'b0;
      s1Or    <= 1'b0;
      s1Col   <= '0;
    end else begin
      s1Box   <= inBox;
      s1Xh    <= xhHit;
      s1Vid   <= vidActive;
      s1CurEn <= ctl.curEn;
      s1Or    <= ctl.orMode;
      s1Col   <= dx[WORD_LOG-1:0];
    end
  end

  always_comb begin
    mBit = bmData[DW - 1 - int'(s1Col)];
    dBit = bmData[WPIX - 1 - int'(s1Col)];
    cp   = s1CurEn && s1Box && mBit;
    cd   = cp && dBit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      curActive <= 1'b0;
      curData   <= 1'b0;
    end else begin
      curActive <= s1Vid && (cp || s1Xh);
      curData   <= s1Vid && (s1Or ? (cd || s1Xh) : (cd ^ s1Xh));
    end
  end
endmodule

// File: rtl/cursorOverlay.sv
module cursorOverlay
  import cursorPkg::*;
#(
  parameter int CW       = 12,
  parameter int DIM_LOG  = 6,
  parameter int WORD_LOG = 3,
  parameter int HSKEW    = 412,
  parameter int VSKEW    = 68,
  localparam int DW      = 2 * (1 << WORD_LOG),
  localparam int AW      = 2 * DIM_LOG - WORD_LOG
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] pixX,
  input  logic [CW-1:0] pixY,
  input  logic          vidActive,
  input  logic [7:0]    cmd,
  input  logic [CW-1:0] curX,
  input  logic [CW-1:0] curY,
  input  logic [CW-1:0] winX,
  input  logic [CW-1:0] winY,
  input  logic [CW-1:0] winW,
  input  logic [CW-1:0] winH,
  input  logic [DW-1:0] bmData,
  output logic [AW-1:0] bmAddr,
  output logic          curActive,
  output logic          curData
);
  ctlT ctl;

  cursorCtrl #(.CW(CW)) u_ctrl (
    .cmd(cmd), .winX(winX), .winY(winY), .winW(winW), .winH(winH), .ctl(ctl)
  );

  cursorPath #(
    .CW(CW), .DIM_LOG(DIM_LOG), .WORD_LOG(WORD_LOG), .HSKEW(HSKEW), .VSKEW(VSKEW)
  ) u_path (
    .clk(clk), .rst_n(rst_n), .pixX(pixX), .pixY(pixY), .vidActive(vidActive),
    .curX(curX), .curY(curY), .winX(winX), .winY(winY), .winW(winW), .winH(winH),
    .ctl(ctl), .bmData(bmData), .bmAddr(bmAddr),
    .curActive(curActive), .curData(curData)
  );
endmodule

// File: rtl/cursorOverlayChk.sv
module cursorOverlayChk (
  input logic       clk,
  input logic       rst_n,
  input logic       vidActive,
  input logic [7:0] cmd,
  input logic       curActive,
  input logic       curData
);
  // R10: blanked pixel gives a dark overlay two clocks on
  a_r10_blank_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(vidActive, 2) |-> (!curActive && !curData));

  // R8: either merge rule only sets colour on pixels the overlay owns
  a_r8_colour_needs_active: assert property (@(posedge clk) disable iff (!rst_n)
    curData |-> curActive);

  // R4, R7: with both enables clear nothing is drawn
  a_r4_no_source_no_overlay: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cmd[6], 2) && !$past(cmd[5], 2)) |-> !curActive);

  // R1: first output after reset is quiet
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (!curActive && !curData));
endmodule

bind cursorOverlay cursorOverlayChk u_chk (
  .clk(clk), .rst_n(rst_n), .vidActive(vidActive), .cmd(cmd),
  .curActive(curActive), .curData(curData)
);

// File: tb/cursorOverlay_tb.sv
module cursorOverlay_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] pixX = '0, pixY = '0, curX = '0, curY = '0;
  logic [11:0] winX = '0, winY = '0, winW = '0, winH = '0;
  logic        vidActive = 1'b0;
  logic [7:0]  cmd = '0;
  logic [15:0] bmData;
  logic [8:0]  bmAddr;
  logic        curActive, curData;

  logic [15:0] mem [0:511];
  int nVec = 0, nBad = 0;
  logic [1:0] h1 = '0, h2 = '0;
  logic       v1 = 1'b0, v2 = 1'b0;
  string      t1 = "", t2 = "";

  always #2.5 clk = ~clk;

  always_ff @(posedge clk) bmData <= mem[bmAddr];

  cursorOverlay u_dut (
    .clk(clk), .rst_n(rst_n), .pixX(pixX), .pixY(pixY), .vidActive(vidActive),
    .cmd(cmd), .curX(curX), .curY(curY), .winX(winX), .winY(winY),
    .winW(winW), .winH(winH), .bmData(bmData), .bmAddr(bmAddr),
    .curActive(curActive), .curData(curData)
  );

  function automatic int modeK(int c);
    int m = (c >> 2) & 3;
    return (m == 1) ? 52 : (m == 2) ? 57 : 37;
  endfunction

  // expected {active, colour} from the requirement text
  function automatic logic [1:0] model(int px, int py, int vid, int c, int ox, int oy,
                                       int wx, int wy, int ww, int wh);
    int dx = (px - ox) & 4095, dy = (py - oy) & 4095;
    int t = c & 3, w;
    logic cp = 0, cd = 0, xp, vh, hh, inWin;
    if (dx < 64 && dy < 64 && ((c >> 6) & 1) == 1) begin
      w  = mem[dy * 8 + dx / 8];
      cp = ((w >> (15 - dx % 8)) & 1) == 1;
      cd = cp && (((w >> (7 - dx % 8)) & 1) == 1);
    end
    vh = ((px - (ox + 32) + t) & 4095) < 2 * t + 1;
    hh = ((py - (oy + 32) + t) & 4095) < 2 * t + 1;
    inWin = (wx == 0 && wy == 0 && ww == 0 && wh == 0) ||
            (((px - wx) & 4095) < ww && ((py - wy) & 4095) < wh);
    xp = (((c >> 5) & 1) == 1) && inWin && (vh || hh);
    if (vid == 0) return 2'b00;
    return {cp || xp, (((c >> 4) & 1) == 1) ? (cd || xp) : (cd ^ xp)};
  endfunction

  task automatic checkOut();
    if (v2) begin
      nVec++;
      if ({curActive, curData} !== h2) begin
        nBad++;
        $display("FAIL %s overlay got %b expected %b", t2, {curActive, curData}, h2);
      end
    end
  endtask

  task automatic runCfg(string tag, int c, int ox, int oy, int wx, int wy,
                        int ww, int wh, int vidPat);
    cmd  = 8'(c);
    curX = 12'((ox + 412 - modeK(c)) & 4095);
    curY = 12'((oy + 68 - 32) & 4095);
    winX = 12'(wx); winY = 12'(wy); winW = 12'(ww); winH = 12'(wh);
    for (int y = oy - 8; y < oy + 72; y++) begin
      for (int x = oy - oy + ox - 8; x < ox + 72; x++) begin
        int px = x & 4095, py = y & 4095;
        int vid = (vidPat != 0 && (px % 5) == 0) ? 0 : 1;
        int dx = (px - ox) & 4095, dy = (py - oy) & 4095;
        @(negedge clk);
        checkOut();
        pixX = 12'(px); pixY = 12'(py); vidActive = vid[0];
        #1;
        if (dx < 64 && dy < 64) begin  // R2 address packing
          nVec++;
          if (int'(bmAddr) != dy * 8 + dx / 8) begin
            nBad++;
            $display("FAIL R2 bmAddr got %0d expected %0d", bmAddr, dy * 8 + dx / 8);
          end
        end
        h2 = h1; v2 = v1; t2 = t1;
        h1 = model(px, py, vid, c, ox, oy, wx, wy, ww, wh);
        v1 = 1'b1; t1 = tag;
      end
    end
  endtask

  initial begin
    for (int i = 0; i < 512; i++)
      mem[i] = 16'((i * 40503 + 12345) ^ (i << 7) ^ (i >> 3));
    repeat (3) @(negedge clk);
    nVec++;  // R1 outputs quiet in reset
    if (curActive !== 1'b0 || curData !== 1'b0) begin
      nBad++;
      $display("FAIL R1 reset outputs got %b expected 00", {curActive, curData});
    end
    rst_n = 1'b1;
    runCfg("R3 R5 mode 1:1",        8'h40, 200, 150,   0,   0,  0,  0, 0);
    runCfg("R5 mode 4:1",           8'h44, 300, 100,   0,   0,  0,  0, 0);
    runCfg("R5 R6 mode 5:1",        8'h48, 120, 400,   0,   0,  0,  0, 0);
    runCfg("R5 mode code 3",        8'h4c,  50,  60,   0,   0,  0,  0, 0);
    runCfg("R7 crosshair t7",       8'h23, 500, 300,   0,   0,  0,  0, 0);
    runCfg("R8 OR merge",           8'h75, 260, 220,   0,   0,  0,  0, 0);
    runCfg("R8 XOR merge",          8'h66, 700, 500,   0,   0,  0,  0, 0);
    runCfg("R9 window clip",        8'h61, 400, 350, 410, 370, 30, 25, 0);
    runCfg("R10 video blank",       8'h73, 330, 240,   0,   0,  0,  0, 1);
    runCfg("R4 cursor erased",      8'h04, 610, 410,   0,   0,  0,  0, 0);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      checkOut();
      vidActive = 1'b0;
      h2 = h1; v2 = v1; t2 = t1; h1 = 2'b00; t1 = "R10 flush";
    end
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired (got hang, expected completion)");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule